// File: doc/BRIEF.md
# Message Object Transfer Port

This block sits between a processor register bus and a 64-entry store of message objects. Software stages a command byte, a mask word, an arbitration word, a control word and eight data bytes in a small set of interface registers. It then writes an object number. That write starts a transfer that either pushes the staged fields into the addressed object or pulls the object's fields back into the interface registers. Separate select bits in the command byte choose which field groups move. A side-effect bit raises the object's transmit request when data is pushed, and drops its new-data flag when data is pulled.

A status bit reports the engine as busy while a transfer is running. Software polls this bit before it touches the interface again. Two single-bit flags per object, transmit-request and new-data, can be read as four 32-bit words each. The receive side of the controller sets new-data through a hook, and the transmit side clears transmit-request through another hook. The serial bus logic itself lies outside this block.

Top module: `mbox_if_xfer`

## Requirements
- R1: After reset, every readable register returns zero, busy is clear, every object field is zero and both flag maps are all zero.
- R2: A write of a number from 1 to 64 to the number register (address 1, bits 7:0) while idle starts a transfer. Status bit 7 (address 2) then reads 1 for exactly 4 cycles and then 0. The transfer takes effect on the clock edge at which busy clears.
- R3: A write of number 0 or of any number above 64 is ignored: busy stays clear and the number register keeps its old value.
- R4: While busy, writes to every interface register (command at address 0, number, mask at 3, arbitration at 4, control at 5, data bytes 3-0 at 6, data bytes 7-4 at 7) have no effect.
- R5: With command bit 7 set, the transfer copies the groups selected by command bit 6 (mask), bit 5 (arbitration), bit 4 (control), bit 1 (data bytes 7-4) and bit 0 (data bytes 3-0) from the interface registers into the object. Fields that are not selected keep their stored values.
- R6: With command bit 7 clear, the transfer copies the selected groups from the object into the interface registers. Interface registers that are not selected keep their values.
- R7: Command bit 2 sets the object's transmit-request flag on a transfer into the object, and clears its new-data flag on a transfer out of the object. With bit 2 clear, neither flag changes.
- R8: Object n appears in flag word (n-1)>>5 at bit (n-1)&31. Transmit-request words are at addresses 8 to 11 and new-data words at addresses 12 to 15. Bits for objects above 64 read zero.
- R9: A receive hook with number n from 1 to 64 sets new-data of object n. A transmit hook with number n clears transmit-request of object n. A hook with number 0 or above 64 changes nothing.
- R10: When a hook and a transfer side effect reach the same flag on the same edge, the hook's value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write register select |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read register select |
| reg_rdata | output | 32 | Read data for reg_raddr (combinational) |
| rx_hit | input | 1 | Receive hook: set new-data of rx_num |
| rx_num | input | 8 | Object number for the receive hook |
| tx_hit | input | 1 | Transmit hook: clear transmit-request of tx_num |
| tx_num | input | 8 | Object number for the transmit hook |

## Verification
The hardest case to reach is a collision: a hook has to land on the same edge as the end of a transfer whose side effect touches the same flag. The bench counts cycles from the start write, so it can raise the hook exactly on the edge where busy clears. It does this once for the new-data flag and once for the transmit-request flag. The stored object fields are visible only through a later read transfer. For that reason, each write scenario is followed by pulls with different group selections, and writes are also issued during busy, so that an ignored field or a lost write shows up at the data registers.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_W  = 8;

    // register selects
    localparam logic [3:0] SEL_CMD  = 4'd0;
    localparam logic [3:0] SEL_NUM  = 4'd1;
    localparam logic [3:0] SEL_STAT = 4'd2;
    localparam logic [3:0] SEL_MASK = 4'd3;
    localparam logic [3:0] SEL_ARB  = 4'd4;
    localparam logic [3:0] SEL_CTL  = 4'd5;
    localparam logic [3:0] SEL_DLO  = 4'd6;
    localparam logic [3:0] SEL_DHI  = 4'd7;

    // command byte bit positions
    localparam int CMD_DIR  = 7;
    localparam int CMD_MASK = 6;
    localparam int CMD_ARB  = 5;
    localparam int CMD_CTL  = 4;
    localparam int CMD_SIDE = 2;
    localparam int CMD_DHI  = 1;
    localparam int CMD_DLO  = 0;
    localparam int STAT_BUSY = 7;

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] arb;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] dlo;
        logic [WORD_W-1:0] dhi;
    } obj_rec_t;

    typedef struct packed {
        logic mask;
        logic arb;
        logic ctl;
        logic dhi;
        logic dlo;
    } grp_sel_t;

    function automatic grp_sel_t cmd_groups(input logic [7:0] cmd);
        grp_sel_t g;
        g.mask = cmd[CMD_MASK];
        g.arb  = cmd[CMD_ARB];
        g.ctl  = cmd[CMD_CTL];
        g.dhi  = cmd[CMD_DHI];
        g.dlo  = cmd[CMD_DLO];
        return g;
    endfunction
endpackage

// File: rtl/mbox_xfer_seq.sv
module mbox_xfer_seq #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(BUSY_CYC - 1);
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == '0);

    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/mbox_obj_store.sv
module mbox_obj_store
    import mbox_pkg::*;
#(
    parameter int NUM_OBJ = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  grp_sel_t                   wsel,
    input  logic [$clog2(NUM_OBJ)-1:0] widx,
    input  obj_rec_t                   wrec,
    input  logic [$clog2(NUM_OBJ)-1:0] ridx,
    output obj_rec_t                   rrec
);
    obj_rec_t mem_d [NUM_OBJ];
    obj_rec_t mem_q [NUM_OBJ];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            if (wsel.mask) mem_d[widx].mask = wrec.mask;
            if (wsel.arb)  mem_d[widx].arb  = wrec.arb;
            if (wsel.ctl)  mem_d[widx].ctl  = wrec.ctl;
            if (wsel.dlo)  mem_d[widx].dlo  = wrec.dlo;
            if (wsel.dhi)  mem_d[widx].dhi  = wrec.dhi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OBJ; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rrec = mem_q[ridx];

    assert_push_arb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsel.arb) |=> mem_q[$past(widx)].arb == $past(wrec.arb));
    assert_keep_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wsel.mask) |=> $stable(mem_q[$past(widx)].mask));
endmodule

// File: rtl/mbox_if_regs.sv
module mbox_if_regs
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              start,
    input  obj_rec_t          ld_rec,
    output logic [7:0]        cmd,
    output logic [NUM_W-1:0]  num,
    output obj_rec_t          ifr
);
    typedef struct packed {
        logic [7:0]       cmd;
        logic [NUM_W-1:0] num;
        obj_rec_t         rec;
    } ifr_st_t;

    ifr_st_t r_d, r_q;
    grp_sel_t gsel;

    assign gsel = cmd_groups(r_q.cmd);

    always_comb begin
        r_d = r_q;
        if (wr && !busy) begin
            case (waddr)
                SEL_CMD:  r_d.cmd      = wdata[7:0];
                SEL_MASK: r_d.rec.mask = wdata;
                SEL_ARB:  r_d.rec.arb  = wdata;
                SEL_CTL:  r_d.rec.ctl  = wdata;
                SEL_DLO:  r_d.rec.dlo  = wdata;
                SEL_DHI:  r_d.rec.dhi  = wdata;
                default: ;
            endcase
        end
        if (start) r_d.num = wdata[NUM_W-1:0];
        if (done && !r_q.cmd[CMD_DIR]) begin
            if (gsel.mask) r_d.rec.mask = ld_rec.mask;
            if (gsel.arb)  r_d.rec.arb  = ld_rec.arb;
            if (gsel.ctl)  r_d.rec.ctl  = ld_rec.ctl;
            if (gsel.dlo)  r_d.rec.dlo  = ld_rec.dlo;
            if (gsel.dhi)  r_d.rec.dhi  = ld_rec.dhi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd = r_q.cmd;
    assign num = r_q.num;
    assign ifr = r_q.rec;

    assert_busy_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(r_q));
    assert_pull_dlo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.cmd[CMD_DIR] && r_q.cmd[CMD_DLO]) |=> r_q.rec.dlo == $past(ld_rec.dlo));
endmodule

// File: rtl/mbox_flag_map.sv
module mbox_flag_map
    import mbox_pkg::*;
#(
    parameter int NUM_OBJ    = 64,
    parameter int FLAG_WORDS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                xfer_done,
    input  logic                                xfer_dir,
    input  logic                                xfer_side,
    input  logic [$clog2(NUM_OBJ)-1:0]          xfer_idx,
    input  logic                                rx_hit,
    input  logic [NUM_W-1:0]                    rx_num,
    input  logic                                tx_hit,
    input  logic [NUM_W-1:0]                    tx_num,
    output logic [FLAG_WORDS-1:0][WORD_W-1:0]   txrq_words,
    output logic [FLAG_WORDS-1:0][WORD_W-1:0]   newd_words
);
    localparam int IDX_W = $clog2(NUM_OBJ);
    localparam int PAD_W = FLAG_WORDS * WORD_W;

    typedef struct packed {
        logic [NUM_OBJ-1:0] txrq;
        logic [NUM_OBJ-1:0] newd;
    } flag_st_t;

    flag_st_t f_d, f_q;
    logic rx_ok, tx_ok;
    logic [IDX_W-1:0] rx_i, tx_i;

    assign rx_ok = rx_hit && (rx_num != '0) && (int'(rx_num) <= NUM_OBJ);
    assign tx_ok = tx_hit && (tx_num != '0) && (int'(tx_num) <= NUM_OBJ);
    assign rx_i  = IDX_W'(rx_num - 1'b1);
    assign tx_i  = IDX_W'(tx_num - 1'b1);

    always_comb begin
        f_d = f_q;
        if (xfer_done && xfer_side) begin
            if (xfer_dir) f_d.txrq[xfer_idx] = 1'b1;
            else          f_d.newd[xfer_idx] = 1'b0;
        end
        // hooks are applied last so they win a same-edge collision
        if (rx_ok) f_d.newd[rx_i] = 1'b1;
        if (tx_ok) f_d.txrq[tx_i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    logic [PAD_W-1:0] tx_pad, nd_pad;
    assign tx_pad = PAD_W'(f_q.txrq);
    assign nd_pad = PAD_W'(f_q.newd);

    for (genvar w = 0; w < FLAG_WORDS; w++) begin : g_word
        assign txrq_words[w] = tx_pad[w*WORD_W +: WORD_W];
        assign newd_words[w] = nd_pad[w*WORD_W +: WORD_W];
    end

    assert_rx_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok |=> f_q.newd[$past(rx_i)]);
    assert_tx_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |=> !f_q.txrq[$past(tx_i)]);
    assert_side_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_dir && xfer_side && !(tx_ok && tx_i == xfer_idx))
        |=> f_q.txrq[$past(xfer_idx)]);
    assert_no_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ok && !tx_ok && !(xfer_done && xfer_side)) |=> $stable(f_q));
endmodule

// File: rtl/mbox_if_xfer.sv
module mbox_if_xfer
    import mbox_pkg::*;
#(
    parameter int NUM_OBJ    = 64,
    parameter int BUSY_CYC   = 4,
    parameter int FLAG_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [3:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    input  logic              rx_hit,
    input  logic [7:0]        rx_num,
    input  logic              tx_hit,
    input  logic [7:0]        tx_num
);
    localparam int IDX_W = $clog2(NUM_OBJ);

    logic             busy, done, start, num_ok;
    logic [7:0]       cmd;
    logic [NUM_W-1:0] num;
    logic [IDX_W-1:0] idx;
    obj_rec_t         ifr, orec;
    logic [FLAG_WORDS-1:0][WORD_W-1:0] txrq_w, newd_w;

    assign num_ok = (reg_wdata[NUM_W-1:0] != '0) && (int'(reg_wdata[NUM_W-1:0]) <= NUM_OBJ);
    assign start  = reg_wr && (reg_waddr == SEL_NUM) && !busy && num_ok;
    assign idx    = IDX_W'(num - 1'b1);

    mbox_xfer_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    mbox_if_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
        .busy(busy), .done(done), .start(start), .ld_rec(orec),
        .cmd(cmd), .num(num), .ifr(ifr)
    );

    mbox_obj_store #(.NUM_OBJ(NUM_OBJ)) u_store (
        .clk(clk), .rst_n(rst_n), .we(done && cmd[CMD_DIR]), .wsel(cmd_groups(cmd)),
        .widx(idx), .wrec(ifr), .ridx(idx), .rrec(orec)
    );

    mbox_flag_map #(.NUM_OBJ(NUM_OBJ), .FLAG_WORDS(FLAG_WORDS)) u_flags (
        .clk(clk), .rst_n(rst_n), .xfer_done(done), .xfer_dir(cmd[CMD_DIR]),
        .xfer_side(cmd[CMD_SIDE]), .xfer_idx(idx),
        .rx_hit(rx_hit), .rx_num(rx_num), .tx_hit(tx_hit), .tx_num(tx_num),
        .txrq_words(txrq_w), .newd_words(newd_w)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            SEL_CMD:  reg_rdata[7:0]       = cmd;
            SEL_NUM:  reg_rdata[7:0]       = num;
            SEL_STAT: reg_rdata[STAT_BUSY] = busy;
            SEL_MASK: reg_rdata = ifr.mask;
            SEL_ARB:  reg_rdata = ifr.arb;
            SEL_CTL:  reg_rdata = ifr.ctl;
            SEL_DLO:  reg_rdata = ifr.dlo;
            SEL_DHI:  reg_rdata = ifr.dhi;
            default: begin
                if (reg_raddr[3:2] == 2'b10) reg_rdata = txrq_w[reg_raddr[1:0]];
                else                         reg_rdata = newd_w[reg_raddr[1:0]];
            end
        endcase
    end

    assert_bad_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_waddr == SEL_NUM && !busy && !num_ok) |=> (!busy && $stable(num)));
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(num));
endmodule

// File: tb/mbox_if_xfer_tb.sv
`timescale 1ns/1ps
module mbox_if_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        rx_hit = 1'b0;
    logic [7:0]  rx_num = '0;
    logic        tx_hit = 1'b0;
    logic [7:0]  tx_num = '0;

    always #5 clk = ~clk;

    mbox_if_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .rx_hit(rx_hit), .rx_num(rx_num), .tx_hit(tx_hit), .tx_num(tx_num)
    );

    // reference model: group g = 0 mask, 1 arb, 2 ctl, 3 data 3-0, 4 data 7-4
    logic [31:0] m_obj [1:64][0:4];
    logic [31:0] m_if  [0:4];
    logic [7:0]  m_cmd, m_num;
    bit          m_tx [1:64];
    bit          m_nd [1:64];
    bit          m_busy;
    int          m_cnt;

    int    checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    function automatic int grp_bit(input int g);
        case (g)
            0: return 6;
            1: return 5;
            2: return 4;
            3: return 0;
            default: return 1;
        endcase
    endfunction

    task automatic model_reset();
        for (int n = 1; n <= 64; n++) begin
            for (int g = 0; g < 5; g++) m_obj[n][g] = '0;
            m_tx[n] = 0; m_nd[n] = 0;
        end
        for (int g = 0; g < 5; g++) m_if[g] = '0;
        m_cmd = '0; m_num = '0; m_busy = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit start_ok, fin;
        int n;
        n = int'(reg_wdata[7:0]);
        start_ok = reg_wr && reg_waddr == 4'd1 && !m_busy && n >= 1 && n <= 64;
        fin = m_busy && m_cnt == 0;
        if (fin) begin
            for (int g = 0; g < 5; g++)
                if (m_cmd[grp_bit(g)]) begin
                    if (m_cmd[7]) m_obj[m_num][g] = m_if[g];
                    else          m_if[g] = m_obj[m_num][g];
                end
            if (m_cmd[2]) begin
                if (m_cmd[7]) m_tx[m_num] = 1;
                else          m_nd[m_num] = 0;
            end
        end
        if (reg_wr && !m_busy) begin
            if (reg_waddr == 4'd0) m_cmd = reg_wdata[7:0];
            else if (reg_waddr >= 4'd3 && reg_waddr <= 4'd7) m_if[int'(reg_waddr) - 3] = reg_wdata;
        end
        if (start_ok) begin
            m_num = reg_wdata[7:0]; m_busy = 1; m_cnt = 3;
        end else if (fin) m_busy = 0;
        else if (m_busy) m_cnt--;
        if (rx_hit && rx_num >= 1 && rx_num <= 64) m_nd[rx_num] = 1;
        if (tx_hit && tx_num >= 1 && tx_num <= 64) m_tx[tx_num] = 0;
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] v = '0;
        case (a)
            0: v[7:0] = m_cmd;
            1: v[7:0] = m_num;
            2: v[7] = m_busy;
            3, 4, 5, 6, 7: v = m_if[a-3];
            default: begin
                for (int b = 0; b < 32; b++) begin
                    int n = ((a & 3) * 32) + b + 1;
                    if (n <= 64) v[b] = (a < 12) ? m_tx[n] : m_nd[n];
                end
            end
        endcase
        return v;
    endfunction

    task automatic compare_all();
        for (int a = 0; a < 16; a++) begin
            reg_raddr = 4'(a);
            #0.2;
            checks++;
            if (reg_rdata !== exp_rd(a)) begin
                fails++;
                $display("FAIL %s addr %0d: actual %h expected %h", cur_req, a, reg_rdata, exp_rd(a));
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic load_if(input logic [31:0] base);
        wr(4'd3, base ^ 32'h1111_0001);
        wr(4'd4, base ^ 32'h2222_0002);
        wr(4'd5, base ^ 32'h3333_0003);
        wr(4'd6, base ^ 32'h4444_0004);
        wr(4'd7, base ^ 32'h5555_0005);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] n);
        wr(4'd0, {24'd0, c});
        wr(4'd1, {24'd0, n});
        idle(5);
    endtask

    initial begin
        model_reset();
        #1;
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        cur_req = "R1"; idle(2);

        cur_req = "R2";
        wr(4'd0, 32'h0000_0000);
        wr(4'd1, 32'd5);
        idle(5);

        cur_req = "R3";
        wr(4'd1, 32'd0);
        wr(4'd1, 32'd65);
        wr(4'd1, 32'd200);
        idle(1);

        cur_req = "R5";
        load_if(32'hA5A5_0000);
        xfer(8'hF7, 8'd33);
        load_if(32'h0F0F_F0F0);
        xfer(8'h93, 8'd2);

        cur_req = "R4";
        wr(4'd0, 32'h0000_00F3);
        wr(4'd1, 32'd10);
        wr(4'd3, 32'hDEAD_0001);
        wr(4'd0, 32'h0000_0000);
        wr(4'd1, 32'd11);
        wr(4'd7, 32'hDEAD_0007);
        idle(3);

        cur_req = "R6";
        for (int a = 3; a <= 7; a++) wr(4'(a), 32'd0);
        xfer(8'h73, 8'd33);
        for (int a = 3; a <= 7; a++) wr(4'(a), 32'hCAFE_0000 + 32'(a));
        xfer(8'h21, 8'd2);
        xfer(8'h53, 8'd10);

        cur_req = "R9";
        rx_hit = 1; rx_num = 8'd1;  tick();
        rx_num = 8'd32; tick();
        rx_num = 8'd64; tick();
        rx_num = 8'd0;  tick();
        rx_num = 8'd65; tick();
        rx_hit = 0;
        tx_hit = 1; tx_num = 8'd33; tick();
        tx_num = 8'd0; tick();
        tx_hit = 0; tick();

        cur_req = "R7";
        xfer(8'h04, 8'd32);
        xfer(8'h00, 8'd64);
        xfer(8'h84, 8'd64);
        xfer(8'h80, 8'd31);

        cur_req = "R8";
        rx_hit = 1;
        rx_num = 8'd31; tick();
        rx_num = 8'd33; tick();
        rx_hit = 0;
        xfer(8'h84, 8'd1);
        xfer(8'h84, 8'd63);

        cur_req = "R10";
        wr(4'd0, 32'h0000_0004);
        wr(4'd1, 32'd1);
        idle(3);
        rx_hit = 1; rx_num = 8'd1; tick();
        rx_hit = 0; idle(1);
        wr(4'd0, 32'h0000_0084);
        wr(4'd1, 32'd63);
        idle(3);
        tx_hit = 1; tx_num = 8'd63; tick();
        tx_hit = 0; idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule